// File: doc/BRIEF.md
# Selector-Mode Address Extension Unit

This unit widens 32-bit effective offsets into 40-bit physical addresses for a pair of index registers. Each register has a slot that is either in plain mode or in selector mode. In plain mode an offset is passed through with zeros above it. In selector mode the slot holds a loaded selector. The selector gives eight high-order address bits, which are placed directly above the 32-bit offset. It also gives a 28-bit limit counted in 4 KB blocks, and the offset is checked against that limit.

A dedicated selector-load command puts one slot into selector mode and latches the selector fields for it. Any ordinary write to the same register, such as clearing it, returns the slot to plain mode. The two slots are independent, so two windows into the 1 TB space can be open at once, and they may overlap or be disjoint. Address requests name a slot and give an offset. The result appears one clock later on registered outputs: an address, a valid flag and a limit-fault flag.

Top module: `ptrsel_xlate`

## Requirements
- R1: After a synchronous reset, both slots are in plain mode and the outputs `pa_valid`, `pa_fault` and `pa_out` are zero.
- R2: A request to a plain-mode slot returns `pa_out` = {8'h00, offset}, with `pa_valid`=1 and `pa_fault`=0, whatever the offset value.
- R3: A load with `ld_idx`=k puts slot k into selector mode. Later requests to slot k return `pa_out[39:32]` = the loaded `ld_ext` and `pa_out[31:0]` = the offset.
- R4: A write event (`wr_valid` with `wr_idx`=k) and no load to slot k returns slot k to plain mode, and its requests are then addressed as in R2. The other slot is not affected.
- R5: Slot 0 and slot 1 keep their own modes and selector fields. A load or write to one slot does not change the results of requests to the other slot.
- R6: In selector mode, a request whose block index offset[31:12] is greater than the loaded limit gives `pa_fault`=1, `pa_valid`=0 and `pa_out`=0. A block index equal to the limit is still valid.
- R7: If a load and a write target the same slot in the same cycle, the load takes effect and the slot ends in selector mode with the new fields.
- R8: Results appear one cycle after the request. A request in the same cycle as a load to its slot sees the slot's previous state. A request in the following cycle sees the new state.
- R9: In a cycle after one with no request, `pa_valid` and `pa_fault` are both 0 and `pa_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Selector-load command strobe |
| ld_idx | input | 1 | Target slot of the selector load |
| ld_ext | input | 8 | High address bits carried by the selector |
| ld_limit | input | 28 | Selector limit in 4 KB blocks |
| wr_valid | input | 1 | Ordinary register-write event |
| wr_idx | input | 1 | Slot written by the ordinary write |
| req_valid | input | 1 | Address request strobe |
| req_idx | input | 1 | Slot that the request uses |
| req_offset | input | 32 | 32-bit effective offset |
| pa_out | output | 40 | Physical address (zero unless valid) |
| pa_valid | output | 1 | Address is valid |
| pa_fault | output | 1 | Limit fault for the request |

## Verification
The case hardest to reach from the ports is a collision in one cycle. A load, a write and a request all target the same slot, so the load-over-write priority and the old-state view of the request must both hold together. Random stimulus rarely lines these up. Directed cycles force them, and the random phase is weighted so that loads, writes and requests share a slot index often. The random phase also picks limits small enough that offsets fall on both sides of the block boundary. Directed cases hit the exact equal-to-limit block and the first block past it.

// File: rtl/ptrsel_pkg.sv
package ptrsel_pkg;
  typedef enum logic {
    MODE_PLAIN = 1'b0,
    MODE_SEL   = 1'b1
  } ptr_mode_e;
endpackage

// File: rtl/ptrsel_slot.sv
module ptrsel_slot
  import ptrsel_pkg::*;
#(
  parameter int EXT_W   = 8,
  parameter int LIM_W   = 28,
  parameter int IDX_W   = 1,
  parameter int SLOT_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [EXT_W-1:0] ld_ext,
  input  logic [LIM_W-1:0] ld_limit,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_idx,
  output ptr_mode_e        mode,
  output logic [EXT_W-1:0] ext,
  output logic [LIM_W-1:0] limit
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SLOT_ID);

  logic ld_hit;
  logic wr_hit;

  assign ld_hit = ld_valid && (ld_idx == MY_IDX);
  assign wr_hit = wr_valid && (wr_idx == MY_IDX);

  // load has priority over an ordinary write in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= MODE_PLAIN;
      ext   <= '0;
      limit <= '0;
    end else if (ld_hit) begin
      mode  <= MODE_SEL;
      ext   <= ld_ext;
      limit <= ld_limit;
    end else if (wr_hit) begin
      mode  <= MODE_PLAIN;
    end
  end

  AST_LOAD_ENTERS_SEL: assert property (@(posedge clk) disable iff (rst)
    ld_hit |=> (mode == MODE_SEL && ext == $past(ld_ext) && limit == $past(ld_limit))); // R3
  AST_WRITE_DROPS_SEL: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !ld_hit) |=> (mode == MODE_PLAIN)); // R4
  AST_LOAD_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && ld_hit) |=> (mode == MODE_SEL)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && !ld_hit) |=> ($stable(mode) && $stable(ext) && $stable(limit))); // R5
endmodule

// File: rtl/ptrsel_limit_chk.sv
module ptrsel_limit_chk #(
  parameter int BLK_W = 20,
  parameter int LIM_W = 28
) (
  input  logic [BLK_W-1:0] blk_idx,
  input  logic [LIM_W-1:0] limit,
  output logic             over
);
  localparam int CMP_W = (BLK_W > LIM_W) ? BLK_W : LIM_W;

  logic [CMP_W-1:0] blk_x;
  logic [CMP_W-1:0] lim_x;

  assign blk_x = CMP_W'(blk_idx);
  assign lim_x = CMP_W'(limit);
  assign over  = blk_x > lim_x;
endmodule

// File: rtl/ptrsel_compose.sv
module ptrsel_compose
  import ptrsel_pkg::*;
#(
  parameter int OFF_W = 32,
  parameter int PA_W  = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  ptr_mode_e           mode,
  input  logic [PA_W-OFF_W-1:0] ext,
  input  logic [OFF_W-1:0]    offset,
  input  logic                over,
  output logic [PA_W-1:0]     pa_out,
  output logic                pa_valid,
  output logic                pa_fault
);
  localparam int EXT_W = PA_W - OFF_W;

  logic            fault_c;
  logic [EXT_W-1:0] hi_c;

  assign fault_c = (mode == MODE_SEL) && over;
  assign hi_c    = (mode == MODE_SEL) ? ext : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_out   <= '0;
      pa_valid <= 1'b0;
      pa_fault <= 1'b0;
    end else begin
      pa_valid <= req_valid && !fault_c;
      pa_fault <= req_valid && fault_c;
      pa_out   <= (req_valid && !fault_c) ? {hi_c, offset} : '0;
    end
  end

  AST_VALID_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pa_valid && pa_fault)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!pa_valid && !pa_fault && pa_out == '0)); // R9
  AST_PLAIN_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == MODE_PLAIN) |=> (pa_valid && pa_out[PA_W-1:OFF_W] == '0)); // R2
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (mode == MODE_PLAIN || !over)) |=> (pa_valid && pa_out[OFF_W-1:0] == $past(offset))); // R3
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    pa_fault |-> (pa_out == '0)); // R6
endmodule

// File: rtl/ptrsel_xlate.sv
module ptrsel_xlate
  import ptrsel_pkg::*;
#(
  parameter int NUM_REGS  = 2,
  parameter int OFF_W     = 32,
  parameter int PA_W      = 40,
  parameter int LIM_W     = 28,
  parameter int BLK_SHIFT = 12,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int EXT_W    = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [EXT_W-1:0] ld_ext,
  input  logic [LIM_W-1:0] ld_limit,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [OFF_W-1:0] req_offset,
  output logic [PA_W-1:0]  pa_out,
  output logic             pa_valid,
  output logic             pa_fault
);
  localparam int BLK_W = OFF_W - BLK_SHIFT;

  ptr_mode_e        slot_mode  [NUM_REGS];
  logic [EXT_W-1:0] slot_ext   [NUM_REGS];
  logic [LIM_W-1:0] slot_limit [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    ptrsel_slot #(
      .EXT_W  (EXT_W),
      .LIM_W  (LIM_W),
      .IDX_W  (IDX_W),
      .SLOT_ID(g)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .ld_valid(ld_valid),
      .ld_idx  (ld_idx),
      .ld_ext  (ld_ext),
      .ld_limit(ld_limit),
      .wr_valid(wr_valid),
      .wr_idx  (wr_idx),
      .mode    (slot_mode[g]),
      .ext     (slot_ext[g]),
      .limit   (slot_limit[g])
    );
  end

  ptr_mode_e        sel_mode;
  logic [EXT_W-1:0] sel_ext;
  logic [LIM_W-1:0] sel_limit;

  always_comb begin
    sel_mode  = MODE_PLAIN;
    sel_ext   = '0;
    sel_limit = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (req_idx == IDX_W'(i)) begin
        sel_mode  = slot_mode[i];
        sel_ext   = slot_ext[i];
        sel_limit = slot_limit[i];
      end
    end
  end

  logic over;

  ptrsel_limit_chk #(
    .BLK_W(BLK_W),
    .LIM_W(LIM_W)
  ) u_chk (
    .blk_idx(req_offset[OFF_W-1:BLK_SHIFT]),
    .limit  (sel_limit),
    .over   (over)
  );

  ptrsel_compose #(
    .OFF_W(OFF_W),
    .PA_W (PA_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .mode     (sel_mode),
    .ext      (sel_ext),
    .offset   (req_offset),
    .over     (over),
    .pa_out   (pa_out),
    .pa_valid (pa_valid),
    .pa_fault (pa_fault)
  );
endmodule

// File: tb/ptrsel_xlate_tb.sv
`timescale 1ns/1ps
module ptrsel_xlate_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_valid, wr_valid, req_valid;
  logic        ld_idx, wr_idx, req_idx;
  logic [7:0]  ld_ext;
  logic [27:0] ld_limit;
  logic [31:0] req_offset;
  logic [39:0] pa_out;
  logic        pa_valid, pa_fault;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model of slot state
  bit          m_sel [2];
  logic [7:0]  m_ext [2];
  logic [27:0] m_lim [2];

  always #2.5 clk = ~clk;

  ptrsel_xlate u_dut (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_ext(ld_ext), .ld_limit(ld_limit),
    .wr_valid(wr_valid), .wr_idx(wr_idx),
    .req_valid(req_valid), .req_idx(req_idx), .req_offset(req_offset),
    .pa_out(pa_out), .pa_valid(pa_valid), .pa_fault(pa_fault)
  );

  function automatic bit exp_fault(input bit sel, input logic [27:0] lim, input logic [31:0] off);
    return sel && ({8'h00, off[31:12]} > lim);
  endfunction

  function automatic logic [39:0] exp_addr(input bit sel, input logic [7:0] e,
                                           input logic [27:0] lim, input logic [31:0] off);
    if (exp_fault(sel, lim, off)) return 40'h0;
    return {sel ? e : 8'h00, off};
  endfunction

  task automatic check(input string tag, input logic [39:0] ea, input bit ev, input bit ef);
    n_tests++;
    if (pa_out !== ea || pa_valid !== ev || pa_fault !== ef) begin
      n_fail++;
      $display("FAIL %s: got pa=%h v=%0b f=%0b, expected pa=%h v=%0b f=%0b",
               tag, pa_out, pa_valid, pa_fault, ea, ev, ef);
    end
  endtask

  // called at a negedge: drives one cycle, checks the result one cycle later
  task automatic step(input bit lv, input bit li, input logic [7:0] le, input logic [27:0] ll,
                      input bit wv, input bit wi, input bit rv, input bit ri,
                      input logic [31:0] ro, input string tag);
    logic [39:0] ea;
    bit ev, ef;
    string t;
    ld_valid = lv; ld_idx = li; ld_ext = le; ld_limit = ll;
    wr_valid = wv; wr_idx = wi;
    req_valid = rv; req_idx = ri; req_offset = ro;
    ef = rv && exp_fault(m_sel[ri], m_lim[ri], ro);
    ev = rv && !ef;
    ea = rv ? exp_addr(m_sel[ri], m_ext[ri], m_lim[ri], ro) : 40'h0;
    t = tag;
    if (t == "") t = !rv ? "R9" : ef ? "R6" : m_sel[ri] ? "R3" : "R2";
    if (lv) begin
      m_sel[li] = 1'b1; m_ext[li] = le; m_lim[li] = ll;
    end
    if (wv && !(lv && li == wi)) m_sel[wi] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(t, ea, ev, ef);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2; i++) begin
      m_sel[i] = 1'b0; m_ext[i] = '0; m_lim[i] = '0;
    end
    rst = 1'b1;
    ld_valid = 0; ld_idx = 0; ld_ext = 0; ld_limit = 0;
    wr_valid = 0; wr_idx = 0; req_valid = 0; req_idx = 0; req_offset = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 40'h0, 1'b0, 1'b0);
    rst = 1'b0;

    // R1: both slots come out of reset in plain mode
    step(0,0,0,0, 0,0, 1,0, 32'hFFFF_FFFF, "R1");
    step(0,0,0,0, 0,0, 1,1, 32'hFFFF_FFFF, "R1");
    // R2: plain pass-through, extreme offsets
    step(0,0,0,0, 0,0, 1,0, 32'h0000_0000, "R2");
    step(0,0,0,0, 0,0, 1,1, 32'h8000_1234, "R2");
    // R9: idle cycle
    step(0,0,0,0, 0,0, 0,0, 32'hDEAD_BEEF, "R9");
    // R3: load slot 0, request next cycle
    step(1,0,8'hA5,28'hFFF_FFFF, 0,0, 0,0, 0, "R9");
    step(0,0,0,0, 0,0, 1,0, 32'h1234_5678, "R3");
    // R8: request in the load cycle sees old state, the next cycle sees new
    step(1,1,8'h3C,28'h000_0010, 0,0, 1,1, 32'h0000_5000, "R8");
    step(0,0,0,0, 0,0, 1,1, 32'h0000_5000, "R8");
    // R5: two windows at once
    step(0,0,0,0, 0,0, 1,0, 32'h0000_5000, "R5");
    step(0,0,0,0, 0,0, 1,1, 32'h0001_0FFF, "R5");
    // R6: boundary on slot 1 (limit 0x10)
    step(0,0,0,0, 0,0, 1,1, 32'h0001_1000, "R6");
    step(1,0,8'h01,28'h000_0005, 0,0, 0,0, 0, "R9");
    step(0,0,0,0, 0,0, 1,0, 32'h0000_5FFF, "R6");
    step(0,0,0,0, 0,0, 1,0, 32'h0000_6000, "R6");
    step(1,0,8'h02,28'h000_0000, 0,0, 0,0, 0, "R9");
    step(0,0,0,0, 0,0, 1,0, 32'h0000_0FFF, "R6");
    step(0,0,0,0, 0,0, 1,0, 32'h0000_1000, "R6");
    // R4: write drops slot 0 only
    step(0,0,0,0, 1,0, 0,0, 0, "R9");
    step(0,0,0,0, 0,0, 1,0, 32'hFFFF_F000, "R4");
    step(0,0,0,0, 0,0, 1,1, 32'h0000_0004, "R4");
    // R7: load and write to slot 0 in one cycle, with a request there too
    step(1,0,8'h77,28'h0FF_FFFF, 1,0, 1,0, 32'h0000_0100, "R7");
    step(0,0,0,0, 0,0, 1,0, 32'h0000_0100, "R7");

    // random phase: heavily shared indices, small limits
    for (int n = 0; n < 3000; n++) begin
      bit lv, li, wv, wi, rv, ri;
      logic [27:0] ll;
      logic [31:0] ro;
      lv = ($urandom % 8) == 0;
      wv = ($urandom % 8) == 0;
      rv = ($urandom % 4) != 0;
      li = $urandom % 2;
      wi = ($urandom % 2) ? li : ~li;
      ri = ($urandom % 2) ? li : ~li;
      ll = ($urandom % 2) ? 28'($urandom % 64) : 28'($urandom);
      ro = ($urandom % 2) ? 32'($urandom % (80 * 4096)) : 32'($urandom);
      step(lv, li, 8'($urandom), ll, wv, wi, rv, ri, ro, "");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule